// File: doc/BRIEF.md
# Atomic Synchronization Word Store

A small shared word memory that several requesting ports reach through a round-robin arbiter. Exactly one request is executed per clock cycle. A read-modify-write therefore finishes inside that cycle and no other access can fall between its read and its write. Lock and counter code running on the requesting agents relies on this block for its primitives:

- plain load and store
- exchange
- test-and-set
- fetch-and-increment
- a load-linked / store-conditional pair, backed by one reservation per port

Each port has a request channel that uses valid/ready. A port raises valid with its opcode, address and write data, and holds all of them steady until ready is seen high at a rising edge. The transfer takes place at that edge. A port that loses arbitration sees ready low, and that is its only back-pressure. It must keep its request unchanged until it is granted. The response channel has no back-pressure. A single-cycle response strobe carries the result on the granted port's data lane in the cycle after the transfer.

Top module: `ssync_top`

## Requirements
- R1: After synchronous reset, every word reads 0, no port holds a reservation (so a store-conditional fails), and no response strobe is high.
- R2: When several ports are valid in a cycle, exactly one is given ready. Priority rotates: after port g is granted, port g+1 (mod port count) comes first. A loser that holds its request is served later.
- R3: The response strobe of the granted port is high for exactly the one cycle after the transfer. No other port's strobe is high in that cycle.
- R4: Opcode 0 (load) returns the word unchanged. Opcode 7 behaves the same as opcode 0. Opcode 1 (store) writes the write data and returns 0.
- R5: Opcode 2 (exchange) writes the write data and returns the previous word. For lock words, 0 means free and 1 means held: an exchange of 1 that returns 0 has acquired the lock.
- R6: Opcode 3 (test-and-set) returns the old word. It writes 1 only when the old word is 0, and otherwise leaves the word unchanged.
- R7: Opcode 4 (fetch-and-increment) returns the old word and stores old+1. The count wraps from all ones to 0 with no indication.
- R8: Opcode 5 (load-linked) returns the word and records a reservation for the issuing port on that address.
- R9: Opcode 6 (store-conditional) with an intact reservation on the same address writes the write data and returns 1.
- R10: A store-conditional returns 0 and writes nothing in three cases: the port has no reservation, its reservation is on another address, or any write to that address from any port (the port's own writes included) has happened since its load-linked. A write here means a store, an exchange, a test-and-set that writes, a fetch-and-increment or a successful store-conditional. A failed store-conditional leaves the port's reservation as it was.
- R11: Writes to other addresses do not break a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NPORT | Request valid, one bit per port |
| req_ready | output | NPORT | Request accepted this cycle, one bit per port |
| req_op | input | 3*NPORT | Opcode per port |
| req_addr | input | AW*NPORT | Word address per port |
| req_wdata | input | DW*NPORT | Write data per port |
| rsp_valid | output | NPORT | Response strobe per port |
| rsp_data | output | DW*NPORT | Response data per port |

## Verification
The exchange tests cover a free lock, a held lock and a lock that has just been released. These cases show that the value returned is the previous word and not the new one. Test-and-set runs on a zero word and on a nonzero word, which shows that the conditional write happens only on 0. Fetch-and-increment runs on small values and on all ones, which shows the wrap. The reservation pair runs clean, broken by the port's own write, broken by another port's write, left untouched by a write elsewhere, and aimed at the wrong address. Each of these shows that reservations are matched by address and port. Three ports then all increment one word in the same cycle. The order of the returned counts exposes the rotation of the arbiter.

// File: rtl/ssync_pkg.sv
package ssync_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FINC  = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_ALT   = 3'd7
  } sync_op_e;
  localparam int OPW = 3;
endpackage

// File: rtl/ssync_rr_arb.sv
module ssync_rr_arb #(
  parameter int NPORT = 3,
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] req,
  output logic [NPORT-1:0] gnt,
  output logic [IW-1:0]    gidx,
  output logic             any
);
  logic [IW-1:0] first_q;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      int k;
      k = (int'(first_q) + i) % NPORT;
      if (!any && req[k]) begin
        any    = 1'b1;
        gnt[k] = 1'b1;
        gidx   = IW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) first_q <= '0;
    else if (any) first_q <= (int'(gidx) == NPORT - 1) ? '0 : gidx + 1'b1;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0)); // R2
  AST_GRANT_WHEN_ASKED: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> $onehot(gnt)); // R2
endmodule

// File: rtl/ssync_resv.sv
module ssync_resv #(
  parameter int NPORT = 3,
  parameter int AW    = 4,
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [IW-1:0] port,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          hit
);
  logic [NPORT-1:0] vld_q;
  logic [AW-1:0]    adr_q [NPORT];

  always_comb begin
    hit = 1'b0;
    for (int p = 0; p < NPORT; p++)
      if (IW'(p) == port && vld_q[p] && adr_q[p] == addr) hit = 1'b1;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[p] <= 1'b0;
        adr_q[p] <= '0;
      end else if (set_en && port == IW'(p)) begin
        vld_q[p] <= 1'b1;
        adr_q[p] <= addr;
      end else if (wr_en && adr_q[p] == wr_addr) begin
        vld_q[p] <= 1'b0;
      end
    end

    AST_WRITE_KILLS_RES: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !(vld_q[p] && adr_q[p] == $past(wr_addr))); // R10
  end
endmodule

// File: rtl/ssync_exec.sv
module ssync_exec #(
  parameter int DW = 32
) (
  input  ssync_pkg::sync_op_e op,
  input  logic [DW-1:0]       old_word,
  input  logic [DW-1:0]       wdata,
  input  logic                res_ok,
  output logic                we,
  output logic [DW-1:0]       new_word,
  output logic [DW-1:0]       result,
  output logic                res_set
);
  import ssync_pkg::*;

  always_comb begin
    we       = 1'b0;
    new_word = old_word;
    result   = old_word;
    res_set  = 1'b0;
    unique case (op)
      OP_STORE: begin we = 1'b1; new_word = wdata; result = '0; end
      OP_SWAP:  begin we = 1'b1; new_word = wdata; end
      OP_TAS:   begin we = (old_word == '0); new_word = DW'(1); end
      OP_FINC:  begin we = 1'b1; new_word = old_word + 1'b1; end
      OP_LL:    res_set = 1'b1;
      OP_SC:    begin we = res_ok; new_word = wdata; result = DW'(res_ok); end
      default:  ;
    endcase
  end
endmodule

// File: rtl/ssync_top.sv
module ssync_top #(
  parameter int NPORT = 3,
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    req_valid,
  output logic [NPORT-1:0]    req_ready,
  input  logic [3*NPORT-1:0]  req_op,
  input  logic [AW*NPORT-1:0] req_addr,
  input  logic [DW*NPORT-1:0] req_wdata,
  output logic [NPORT-1:0]    rsp_valid,
  output logic [DW*NPORT-1:0] rsp_data
);
  import ssync_pkg::*;

  logic [NPORT-1:0] gnt;
  logic [IW-1:0]    gidx;
  logic             busy;
  sync_op_e         s_op;
  logic [AW-1:0]    s_addr;
  logic [DW-1:0]    s_wdata, old_word, new_word, result;
  logic             we, res_ok, res_set;
  logic [DW-1:0]    mem [DEPTH];

  ssync_rr_arb #(.NPORT(NPORT)) u_arb (
    .clk(clk), .rst(rst), .req(req_valid), .gnt(gnt), .gidx(gidx), .any(busy)
  );

  assign req_ready = gnt;
  assign s_op      = sync_op_e'(req_op[gidx*OPW +: OPW]);
  assign s_addr    = req_addr[gidx*AW +: AW];
  assign s_wdata   = req_wdata[gidx*DW +: DW];
  assign old_word  = mem[s_addr];

  ssync_resv #(.NPORT(NPORT), .AW(AW)) u_resv (
    .clk(clk), .rst(rst),
    .set_en(busy && res_set), .port(gidx), .addr(s_addr),
    .wr_en(busy && we), .wr_addr(s_addr), .hit(res_ok)
  );

  ssync_exec #(.DW(DW)) u_exec (
    .op(s_op), .old_word(old_word), .wdata(s_wdata), .res_ok(res_ok),
    .we(we), .new_word(new_word), .result(result), .res_set(res_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (busy && we) begin
      mem[s_addr] <= new_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= gnt;
      if (busy) rsp_data[gidx*DW +: DW] <= result;
    end
  end

  AST_RSP_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (rst)
    ##1 rsp_valid == $past(req_valid & req_ready)); // R3
  AST_FINC_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && s_op == OP_FINC) |=> mem[$past(s_addr)] == $past(old_word) + 1'b1); // R7
  AST_TAS_HOLDS_SET: assert property (@(posedge clk) disable iff (rst)
    (busy && s_op == OP_TAS && old_word != '0) |=> mem[$past(s_addr)] == $past(old_word)); // R6
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (busy && (s_op == OP_LOAD || s_op == OP_LL)) |=> mem[$past(s_addr)] == $past(old_word)); // R4
  AST_SWAP_WRITES: assert property (@(posedge clk) disable iff (rst)
    (busy && s_op == OP_SWAP) |=> mem[$past(s_addr)] == $past(s_wdata)); // R5
endmodule

// File: tb/ssync_top_test.sv
module ssync_top_test;
  localparam int NP = 3, AW = 4, DW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [NP-1:0]    req_valid = '0;
  logic [NP-1:0]    req_ready;
  logic [3*NP-1:0]  req_op = '0;
  logic [AW*NP-1:0] req_addr = '0;
  logic [DW*NP-1:0] req_wdata = '0;
  logic [NP-1:0]    rsp_valid;
  logic [DW*NP-1:0] rsp_data;

  int checks = 0, errors = 0;
  int          q_port[$];
  logic [31:0] q_data[$];
  string       q_tag[$];
  logic        done = 1'b0;

  always #5 clk = ~clk;

  ssync_top #(.NPORT(NP), .DEPTH(16), .DW(DW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each response is compared with the oldest expectation.
  always @(negedge clk) begin
    if (!rst) begin
      check($countones(rsp_valid) <= 1, "R3 one strobe", 32'(rsp_valid), 32'd1);
      for (int p = 0; p < NP; p++) begin
        if (rsp_valid[p]) begin
          if (q_port.size() == 0) begin
            check(1'b0, "R3 unexpected response", 32'(p), 32'hFFFFFFFF);
          end else begin
            int ep; logic [31:0] ed; string et;
            ep = q_port.pop_front(); ed = q_data.pop_front(); et = q_tag.pop_front();
            check(ep == p, {et, " port"}, 32'(p), 32'(ep));
            check(rsp_data[p*DW +: DW] == ed, et, rsp_data[p*DW +: DW], ed);
          end
        end
      end
    end
  end

  // Driver: one request on one port, expectation pushed at the transfer cycle.
  task automatic issue(input int p, input logic [2:0] op, input logic [3:0] a,
                       input logic [31:0] wd, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid[p] = 1'b1;
    req_op[p*3 +: 3] = op;
    req_addr[p*AW +: AW] = a;
    req_wdata[p*DW +: DW] = wd;
    #1;
    while (!req_ready[p]) begin
      @(negedge clk); #1;
    end
    q_port.push_back(p); q_data.push_back(exp); q_tag.push_back(tag);
    @(posedge clk);
    #1 req_valid[p] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    done = 1'b1;
  end

  initial begin
    int order[3];
    int got;
    logic [31:0] cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rsp_valid == '0, "R1 strobes low in reset", 32'(rsp_valid), 32'd0);
    rst = 1'b0;

    issue(0, 3'd0, 4'd0, 0, 0, "R1 word 0 cleared");
    issue(1, 3'd0, 4'd5, 0, 0, "R1 word 5 cleared");
    issue(2, 3'd7, 4'd15, 0, 0, "R1 word 15 cleared (op 7 as load, R4)");
    issue(1, 3'd6, 4'd3, 32'd9, 0, "R1 SC without reservation after reset");
    issue(0, 3'd0, 4'd3, 0, 0, "R10 failed SC left word");

    issue(0, 3'd1, 4'd2, 32'hA5, 0, "R4 store returns 0");
    issue(1, 3'd0, 4'd2, 0, 32'hA5, "R4 load sees store");

    issue(0, 3'd2, 4'd4, 1, 0, "R5 exchange acquires free lock");
    issue(1, 3'd2, 4'd4, 1, 1, "R5 exchange sees held lock");
    issue(0, 3'd1, 4'd4, 0, 0, "R5 release store");
    issue(2, 3'd2, 4'd4, 1, 0, "R5 exchange after release");
    issue(2, 3'd2, 4'd4, 32'h77, 1, "R5 exchange returns previous");
    issue(0, 3'd0, 4'd4, 0, 32'h77, "R5 exchange wrote data");

    issue(1, 3'd3, 4'd6, 0, 0, "R6 TAS on zero");
    issue(2, 3'd3, 4'd6, 0, 1, "R6 TAS on set word");
    issue(0, 3'd0, 4'd6, 0, 1, "R6 TAS wrote 1");
    issue(0, 3'd1, 4'd7, 5, 0, "R4 store 5");
    issue(1, 3'd3, 4'd7, 0, 5, "R6 TAS on nonzero returns old");
    issue(0, 3'd0, 4'd7, 0, 5, "R6 nonzero word unchanged");

    issue(0, 3'd4, 4'd8, 0, 0, "R7 FINC from 0");
    issue(1, 3'd4, 4'd8, 0, 1, "R7 FINC from 1");
    issue(2, 3'd0, 4'd8, 0, 2, "R7 FINC result 2");
    issue(0, 3'd1, 4'd9, 32'hFFFFFFFF, 0, "R4 store all ones");
    issue(1, 3'd4, 4'd9, 0, 32'hFFFFFFFF, "R7 FINC returns all ones");
    issue(2, 3'd0, 4'd9, 0, 0, "R7 FINC wraps to 0");

    issue(0, 3'd1, 4'd10, 32'h33, 0, "R4 store 0x33");
    issue(0, 3'd5, 4'd10, 0, 32'h33, "R8 LL returns word");
    issue(0, 3'd6, 4'd10, 32'h44, 1, "R9 SC with intact reservation");
    issue(1, 3'd0, 4'd10, 0, 32'h44, "R9 SC wrote data");
    issue(0, 3'd6, 4'd10, 32'h55, 0, "R10 own successful SC cleared reservation");
    issue(1, 3'd0, 4'd10, 0, 32'h44, "R10 failed SC left word");

    issue(1, 3'd5, 4'd11, 0, 0, "R8 LL on word 11");
    issue(2, 3'd1, 4'd11, 7, 0, "R4 other port store");
    issue(1, 3'd6, 4'd11, 8, 0, "R10 SC after other port store");
    issue(0, 3'd0, 4'd11, 0, 7, "R10 word keeps store value");

    issue(0, 3'd5, 4'd12, 0, 0, "R8 LL port 0");
    issue(1, 3'd5, 4'd12, 0, 0, "R8 LL port 1");
    issue(2, 3'd4, 4'd13, 0, 0, "R11 FINC elsewhere");
    issue(2, 3'd1, 4'd13, 3, 0, "R11 store elsewhere");
    issue(1, 3'd6, 4'd12, 32'h21, 1, "R11 reservation survives other-address writes");
    issue(0, 3'd6, 4'd12, 32'h22, 0, "R10 reservation broken by SC of other port");
    issue(2, 3'd0, 4'd12, 0, 32'h21, "R9 winning SC value kept");

    issue(2, 3'd5, 4'd14, 0, 0, "R8 LL word 14");
    issue(2, 3'd6, 4'd15, 32'h9, 0, "R10 SC to other address fails");
    issue(2, 3'd6, 4'd14, 32'h6, 1, "R10 failed SC kept reservation");
    issue(0, 3'd0, 4'd15, 0, 0, "R10 word 15 untouched");

    // Contention: last grant went to port 0, so the rotation is 1, 2, 0.
    order = '{1, 2, 0};
    got = 0; cnt = 0;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      req_valid[p] = 1'b1;
      req_op[p*3 +: 3] = 3'd4;
      req_addr[p*AW +: AW] = 4'd1;
    end
    while (got < NP) begin
      #1;
      check($countones(req_ready) == 1, "R2 single ready", 32'(req_ready), 32'd1);
      for (int p = 0; p < NP; p++) begin
        if (req_ready[p]) begin
          check(p == order[got], "R2 rotation order", 32'(p), 32'(order[got]));
          q_port.push_back(p); q_data.push_back(cnt); q_tag.push_back("R2 contended FINC");
          cnt++;
          got++;
          @(posedge clk);
          #1 req_valid[p] = 1'b0;
          break;
        end
      end
      @(negedge clk);
    end
    issue(1, 3'd0, 4'd1, 0, 3, "R2 all three increments applied");

    repeat (4) @(negedge clk);
    check(q_port.size() == 0, "R3 all responses seen", 32'(q_port.size()), 32'd0);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule